// File: doc/BRIEF.md
# Toggle-Handshake Elastic Queue

This block is a small first-in first-out buffer placed between two pipeline stages that talk with a two-phase, transition-signalled handshake. It is a clocked model of a self-timed micropipeline. On each side a sender flips a `go` line to announce a word on the data bus. The receiver flips an `ack` line to take it. Only the change of a line matters, never its level, so a rising edge and a falling edge are each one event.

The upstream side registers the incoming `go` level. It sees an offer whenever that registered level differs from the level of its own `up_ack`, and it accepts the offer only when a slot is free or one is being freed in the same cycle. A full queue therefore holds the sender without dropping its word. The downstream side is a two-state machine. In `TX_IDLE` the previous offer has been acknowledged. `LAUNCH` (IDLE to OFFER) flips `dn_go` as soon as a word is stored. In `TX_OFFER` the machine waits for the registered `dn_ack` to match `dn_go`. When it matches, the head entry is retired. If the queue then still holds a word, `RELAUNCH` (OFFER to OFFER) flips `dn_go` again at once; otherwise `RETIRE` (OFFER to IDLE) is taken. The depth is a parameter. A depth of 1 still moves one word every two cycles, and more depth absorbs rate jitter between the stages.

Top module: `tq_elastic`

## Requirements
- R1: While `rst_n` is low, `up_ack` and `dn_go` are 0 and the queue is empty.
- R2: Each upstream offer (a change of `up_go` away from `up_ack`) is answered by exactly one change of `up_ack`, whichever direction the change takes.
- R3: Words leave on `dn_data` in the order they were accepted, with values unchanged, and each word is offered by exactly one change of `dn_go`.
- R4: With downstream stalled, exactly DEPTH offers are acknowledged. The next offer stays pending, with `up_go` different from `up_ack`, and is delivered after the stall ends.
- R5: After n complete transfers, `up_ack` and `dn_go` are both at level n mod 2.
- R6: With the queue empty, `dn_go` changes on the third rising clock edge after the `up_go` change.
- R7: `dn_data` holds its value while a downstream offer is outstanding (`dn_go` different from `dn_ack`).
- R8: With partners that answer within one cycle, N transfers complete within 2N+8 cycles at depth 1 and at depth 2.
- R9: Without upstream events, `up_ack` and `dn_go` do not change once the queue has drained.
- R10: `dn_go` changes only when the previous downstream offer has been acknowledged, that is when `dn_go` equals the registered `dn_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_go | input | 1 | Upstream offer line; each change marks a new word |
| up_data | input | W | Upstream word, stable from the `up_go` change until `up_ack` answers |
| up_ack | output | 1 | Upstream accept line; flips once per accepted word |
| dn_go | output | 1 | Downstream offer line; flips once per word offered |
| dn_data | output | W | Head word, held while the downstream offer is outstanding |
| dn_ack | input | 1 | Downstream accept line; flips to take the offered word |

## Verification
The queue is tried at depths 1 and 2, each with a sender and receiver that answer in the next half cycle. The sequence starts with a lone word, which isolates the empty-queue latency. A stalled receiver then fills the queue and shows where the acknowledgements stop and that the waiting word survives the stall. An unbroken stream then separates the combined retire-and-accept path, which the depth-1 rate depends on, from a version that would need a bubble. A quiet period at the end catches spurious handshake events. Word values are an arithmetic function of their index, so any reordering, loss or duplication appears as a mismatch, and the number of transfers also fixes the expected line levels.

// File: rtl/tq_pkg.sv
package tq_pkg;
    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_OFFER = 1'b1
    } tx_state_t;
endpackage

// File: rtl/tq_rx.sv
module tq_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic up_go,
    input  logic full,
    input  logic pop,
    output logic push,
    output logic up_ack
);
    logic go_q;
    logic ack_lvl;
    logic pending;

    assign pending = go_q ^ ack_lvl;
    assign push    = pending && (!full || pop);
    assign up_ack  = ack_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            ack_lvl <= 1'b0;
        end else begin
            go_q    <= up_go;
            ack_lvl <= ack_lvl ^ push;
        end
    end

    // R2
    ack_on_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_lvl) |-> ($past(go_q) != $past(ack_lvl)));
endmodule

// File: rtl/tq_store.sv
module tq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         refill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, cnt_nxt;

    assign cnt_nxt = cnt + CW'(push) - CW'(pop);
    assign full    = (cnt == CMAX);
    assign empty   = (cnt == '0);
    assign refill  = (cnt_nxt != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PW'(i)) mem[i] <= wdata;
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt < CMAX));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/tq_tx.sv
module tq_tx
    import tq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         empty,
    input  logic         refill,
    input  logic         dn_ack,
    input  logic [W-1:0] head,
    output logic         dn_go,
    output logic [W-1:0] dn_data,
    output logic         pop
);
    tx_state_t state, state_nxt;
    logic go_lvl, ack_q, flip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            go_lvl <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            state  <= state_nxt;
            go_lvl <= go_lvl ^ flip;
            ack_q  <= dn_ack;
        end
    end

    always_comb begin
        state_nxt = state;
        flip      = 1'b0;
        pop       = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (!empty) begin
                    flip      = 1'b1;
                    state_nxt = TX_OFFER;
                end
            end
            TX_OFFER: begin
                if (ack_q == go_lvl) begin
                    pop = 1'b1;
                    if (refill) flip = 1'b1;
                    else        state_nxt = TX_IDLE;
                end
            end
            default: state_nxt = TX_IDLE;
        endcase
    end

    assign dn_go   = go_lvl;
    assign dn_data = head;

    // R10
    offer_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(go_lvl) |-> ($past(go_lvl) == $past(ack_q)));
    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_OFFER && !pop) |=> $stable(head));
endmodule

// File: rtl/tq_elastic.sv
module tq_elastic #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_go,
    input  logic [W-1:0] up_data,
    output logic         up_ack,
    output logic         dn_go,
    output logic [W-1:0] dn_data,
    input  logic         dn_ack
);
    logic push, pop, full, empty, refill;
    logic [W-1:0] head;

    tq_rx u_rx (
        .clk(clk), .rst_n(rst_n), .up_go(up_go), .full(full),
        .pop(pop), .push(push), .up_ack(up_ack)
    );

    tq_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(up_data),
        .head(head), .full(full), .empty(empty), .refill(refill)
    );

    tq_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .empty(empty), .refill(refill),
        .dn_ack(dn_ack), .head(head), .dn_go(dn_go), .dn_data(dn_data),
        .pop(pop)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!up_ack && !dn_go));
endmodule

// File: tb/sim_tq_elastic.sv
`timescale 1ns/1ps
module sim_tq_elastic;
    localparam int W = 8;
    localparam int DEP [2] = '{2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         up_go  [2] = '{1'b0, 1'b0};
    logic [W-1:0] up_data[2] = '{8'h00, 8'h00};
    logic         dn_ack [2] = '{1'b0, 1'b0};
    logic         up_ack [2];
    logic         dn_go  [2];
    logic [W-1:0] dn_data[2];

    tq_elastic #(.W(W), .DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .up_go(up_go[0]), .up_data(up_data[0]),
        .up_ack(up_ack[0]), .dn_go(dn_go[0]), .dn_data(dn_data[0]), .dn_ack(dn_ack[0])
    );
    tq_elastic #(.W(W), .DEPTH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .up_go(up_go[1]), .up_data(up_data[1]),
        .up_ack(up_ack[1]), .dn_go(dn_go[1]), .dn_data(dn_data[1]), .dn_ack(dn_ack[1])
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    bit snd_en = 0, rcv_en = 1;
    int snd_total[2] = '{0, 0};
    int sent[2] = '{0, 0}, rcvd[2] = '{0, 0};
    int acked[2] = '{0, 0}, offers[2] = '{0, 0};
    int t_go[2] = '{-1, -1}, t_dn[2] = '{-1, -1};
    logic ack_prev[2] = '{1'b0, 1'b0}, dgo_prev[2] = '{1'b0, 1'b0};

    function automatic logic [W-1:0] pat(int k, int i);
        return W'(i * 37 + k * 5 + 3);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (up_ack[k] != ack_prev[k]) acked[k]++;
                if (dn_go[k] != dgo_prev[k]) begin
                    offers[k]++;
                    if (t_dn[k] < 0) t_dn[k] = cyc;
                end
                ack_prev[k] = up_ack[k];
                dgo_prev[k] = dn_go[k];
                if (dn_go[k] != dn_ack[k]) begin
                    if (rcv_en) begin
                        chk(dn_data[k] == pat(k, rcvd[k]), "R3 data order", dn_data[k], pat(k, rcvd[k]));
                        dn_ack[k] = ~dn_ack[k];
                        rcvd[k]++;
                    end else begin
                        chk(dn_data[k] == pat(k, rcvd[k]), "R7 data hold", dn_data[k], pat(k, rcvd[k]));
                    end
                end
                if (snd_en && up_ack[k] == up_go[k] && sent[k] < snd_total[k]) begin
                    up_data[k] = pat(k, sent[k]);
                    up_go[k] = ~up_go[k];
                    if (t_go[k] < 0) t_go[k] = cyc;
                    sent[k]++;
                end
            end
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        int base[2];
        int a0[2], o0[2];
        logic la[2], lg[2];
        wait_cycles(3);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(up_ack[k] == 1'b0, "R1 up_ack reset", up_ack[k], 0);
            chk(dn_go[k] == 1'b0, "R1 dn_go reset", dn_go[k], 0);
        end
        rst_n = 1'b1;
        wait_cycles(2);

        // R6: single word into an empty queue
        snd_total = '{1, 1};
        snd_en = 1;
        wait_cycles(12);
        for (int k = 0; k < 2; k++) begin
            chk(t_dn[k] - t_go[k] == 3, "R6 latency", t_dn[k] - t_go[k], 3);
            chk(rcvd[k] == 1, "R3 single word", rcvd[k], 1);
        end

        // R4: stall downstream, fill the queue
        rcv_en = 0;
        for (int k = 0; k < 2; k++) begin
            base[k] = acked[k];
            snd_total[k] = snd_total[k] + DEP[k] + 3;
        end
        wait_cycles(30);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(acked[k] - base[k] == DEP[k], "R4 accepted while full", acked[k] - base[k], DEP[k]);
            chk(up_go[k] != up_ack[k], "R4 offer pending", up_ack[k], !up_go[k]);
        end
        rcv_en = 1;
        wait_cycles(60);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(rcvd[k] == snd_total[k], "R4 nothing lost", rcvd[k], snd_total[k]);
            chk(acked[k] == sent[k], "R2 one ack per offer", acked[k], sent[k]);
            chk(offers[k] == rcvd[k], "R10 one offer per word", offers[k], rcvd[k]);
            chk(up_ack[k] == 1'(sent[k] % 2), "R5 up_ack level", up_ack[k], sent[k] % 2);
            chk(dn_go[k] == 1'(rcvd[k] % 2), "R5 dn_go level", dn_go[k], rcvd[k] % 2);
        end

        // R8: streaming throughput
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            base[k] = rcvd[k];
            snd_total[k] = snd_total[k] + 32;
        end
        wait_cycles(2 * 32 + 8);
        @(negedge clk);
        for (int k = 0; k < 2; k++)
            chk(rcvd[k] - base[k] == 32, "R8 throughput", rcvd[k] - base[k], 32);

        // R9: quiet period
        for (int k = 0; k < 2; k++) begin
            a0[k] = acked[k]; o0[k] = offers[k];
            la[k] = up_ack[k]; lg[k] = dn_go[k];
        end
        wait_cycles(20);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(acked[k] == a0[k] && up_ack[k] == la[k], "R9 up_ack quiet", acked[k], a0[k]);
            chk(offers[k] == o0[k] && dn_go[k] == lg[k], "R9 dn_go quiet", offers[k], o0[k]);
            chk(up_ack[k] == 1'(sent[k] % 2), "R5 final up_ack level", up_ack[k], sent[k] % 2);
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule